// File: doc/BRIEF.md
# Quality Detector Attack/Decay Smoother

This block conditions the raw FM quality samples (signal level, multipath, ultrasonic noise and wideband-AM) before they reach the weak-signal control curves. It is a bank of first-order trackers, and each tracker has its own rise and fall time constant. All trackers advance only on a sample tick. The level and multipath time constants come from small selection fields. A fast/slow bit modifies the level table, and a search bit forces one short constant onto both paths. A hold input freezes the control smoothers while an alternative frequency is being checked.

Two extra trackers follow the noise and wideband-AM samples with a fast rise and a slow fall, and their outputs feed register readout. The block also derives an effective noise-detector sensitivity from the smoothed level. It lowers the programmed sensitivity step as the level falls.

Each time constant `t` is turned into a shift `k` at elaboration time, based on the tick period parameter `TICK_US`. A tracker keeps `W+FRAC` bits of state and presents the `W`-bit integer part.

Top module: `qd_smoother`

## Requirements
- R1: On a cycle with `tick_i` high, each active tracker updates its state `y` as `y += (x·2^FRAC − y) >>> k`, using arithmetic shift and floor rounding. `k` is the rise shift when `x·2^FRAC > y` and the fall shift otherwise. The output is the integer part `y >> FRAC` and appears after that clock edge. No state changes on a cycle without a tick.
- R2: A time constant `t` maps to `k = ceil(log2(ceil(t / TICK_US)))`, so a constant at or below one tick gives `k = 0`.
- R3: The level tracker selects its times with `lvl_tc_i`, indexed 0..3. Rise times are 3, 3, 1.5, 0.5 s when `lvl_fast_i` = 0 and 0.5, 0.17, 0.06, 0.06 s when it is 1. Fall times are 3, 6, 1.5, 1.5 s when `lvl_fast_i` = 0 and 0.5, 0.5, 0.17, 0.06 s when it is 1.
- R4: The multipath tracker selects its times with `mph_tc_i`, indexed 0..3. Rise times are 0.5, 0.5, 0.5, 0.25 s and fall times are 12, 24, 6, 6 s.
- R5: With `search_i` high, the level and multipath trackers use 60 ms for both rise and fall, whatever their selection fields hold.
- R6: The noise and wideband-AM control trackers use 1 ms for both rise and fall.
- R7: The two readout peak trackers use 1 ms rise and 10 ms fall. Neither `hold_i` nor `search_i` affects them.
- R8: While `hold_i` is high, the level, multipath, noise and wideband-AM control outputs keep their values.
- R9: The automatic sensitivity limit is 3 when `lvl_o` ≥ 64, 2 when it is ≥ 56, 1 when it is ≥ 48, and 0 otherwise. These codes correspond to 1.25 V, 1.125 V and 1.0 V on a 0.25 V offset with 15.7 mV per code. `usn_sens_o` is the smaller of this limit and `usn_sens_i`.
- R10: After reset all tracker states are zero, so every output, including `usn_sens_o`, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sample tick; trackers step when high |
| hold_i | input | 1 | Freezes the four control trackers |
| search_i | input | 1 | Forces 60 ms on level and multipath |
| lvl_fast_i | input | 1 | Selects the fast level table |
| lvl_tc_i | input | 2 | Level time-constant select |
| mph_tc_i | input | 2 | Multipath time-constant select |
| usn_sens_i | input | 2 | Programmed noise sensitivity step |
| lvl_raw_i | input | W | Raw level sample |
| mph_raw_i | input | W | Raw multipath sample |
| usn_raw_i | input | W | Raw ultrasonic-noise sample |
| wam_raw_i | input | W | Raw wideband-AM sample |
| lvl_o | output | W | Smoothed level |
| mph_o | output | W | Smoothed multipath |
| usn_o | output | W | Smoothed noise for controls |
| wam_o | output | W | Smoothed wideband-AM for controls |
| usn_pk_o | output | W | Noise peak for readout |
| wam_pk_o | output | W | Wideband-AM peak for readout |
| usn_sens_o | output | 2 | Effective noise sensitivity |

## Verification
The bench uses the defaults W = 8, FRAC = 16 and TICK_US = 1000. This gives shifts from 0 (the 1 ms trackers and instant peak rise) up to 15 (the 24 s multipath fall), with the search constant at shift 6. It sweeps every combination of search, fast bit and both selection fields through a rising and a falling input phase. This covers every entry of both tables, and under the short constants it carries the smoothed level across all three sensitivity thresholds while the programmed step changes. Hold and tick-free intervals with changing inputs show that the control outputs stay frozen while the peak trackers keep moving.

// File: rtl/qd_smooth_pkg.sv
package qd_smooth_pkg;

  // shift k such that 2^k >= ceil(t/tick)
  function automatic int tc_shift(longint t_us, longint tick_us, int max_k);
    longint n;
    int k;
    n = (t_us + tick_us - 1) / tick_us;
    k = 0;
    for (int i = 0; i < 48; i++)
      if ((longint'(1) << k) < n) k++;
    if (k > max_k) k = max_k;
    return k;
  endfunction

  // first level code strictly above a voltage in mV (0.25 V offset, 15.7 mV/code)
  function automatic int lvl_code_above(int mv);
    return ((mv - 250) * 10) / 157 + 1;
  endfunction

  localparam int LVL_THR1 = lvl_code_above(1000);
  localparam int LVL_THR2 = lvl_code_above(1125);
  localparam int LVL_THR3 = lvl_code_above(1250);

  localparam longint SEARCH_US  = 60000;
  localparam longint CTRL_US    = 1000;
  localparam longint PK_ATK_US  = 1000;
  localparam longint PK_DEC_US  = 10000;

endpackage

// File: rtl/qd_track.sv
module qd_track #(
  parameter int W    = 8,
  parameter int FRAC = 16,
  parameter int KW   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [W-1:0]  x_i,
  input  logic [KW-1:0] k_atk_i,
  input  logic [KW-1:0] k_dec_i,
  output logic [W-1:0]  y_o
);
  localparam int SW = W + FRAC;

  logic [SW-1:0]      y_q, y_d;
  logic signed [SW:0] diff, delta, sum;
  logic [KW-1:0]      k_sel;

  always_comb begin
    diff  = $signed({1'b0, x_i, {FRAC{1'b0}}}) - $signed({1'b0, y_q});
    k_sel = (diff > 0) ? k_atk_i : k_dec_i;
    delta = diff >>> k_sel;
    sum   = $signed({1'b0, y_q}) + delta;
    y_d   = sum[SW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     y_q <= '0;
    else if (step_i) y_q <= y_d;
  end

  assign y_o = y_q[SW-1:FRAC];
endmodule

// File: rtl/qd_tc_sel.sv
module qd_tc_sel #(
  parameter int TICK_US = 1000,
  parameter int KW      = 5,
  parameter int MAX_K   = 24
) (
  input  logic          search_i,
  input  logic          lvl_fast_i,
  input  logic [1:0]    lvl_tc_i,
  input  logic [1:0]    mph_tc_i,
  output logic [KW-1:0] lvl_atk_k_o,
  output logic [KW-1:0] lvl_dec_k_o,
  output logic [KW-1:0] mph_atk_k_o,
  output logic [KW-1:0] mph_dec_k_o
);
  import qd_smooth_pkg::*;

  localparam longint T = TICK_US;

  localparam int LA_SLOW[4] = '{tc_shift(3000000, T, MAX_K), tc_shift(3000000, T, MAX_K),
                                tc_shift(1500000, T, MAX_K), tc_shift(500000, T, MAX_K)};
  localparam int LA_FAST[4] = '{tc_shift(500000, T, MAX_K), tc_shift(170000, T, MAX_K),
                                tc_shift(60000, T, MAX_K), tc_shift(60000, T, MAX_K)};
  localparam int LD_SLOW[4] = '{tc_shift(3000000, T, MAX_K), tc_shift(6000000, T, MAX_K),
                                tc_shift(1500000, T, MAX_K), tc_shift(1500000, T, MAX_K)};
  localparam int LD_FAST[4] = '{tc_shift(500000, T, MAX_K), tc_shift(500000, T, MAX_K),
                                tc_shift(170000, T, MAX_K), tc_shift(60000, T, MAX_K)};
  localparam int MA[4]      = '{tc_shift(500000, T, MAX_K), tc_shift(500000, T, MAX_K),
                                tc_shift(500000, T, MAX_K), tc_shift(250000, T, MAX_K)};
  localparam int MD[4]      = '{tc_shift(12000000, T, MAX_K), tc_shift(24000000, T, MAX_K),
                                tc_shift(6000000, T, MAX_K), tc_shift(6000000, T, MAX_K)};
  localparam int KS         = tc_shift(SEARCH_US, T, MAX_K);

  always_comb begin
    if (search_i) begin
      lvl_atk_k_o = KW'(KS);
      lvl_dec_k_o = KW'(KS);
      mph_atk_k_o = KW'(KS);
      mph_dec_k_o = KW'(KS);
    end else begin
      lvl_atk_k_o = lvl_fast_i ? KW'(LA_FAST[lvl_tc_i]) : KW'(LA_SLOW[lvl_tc_i]);
      lvl_dec_k_o = lvl_fast_i ? KW'(LD_FAST[lvl_tc_i]) : KW'(LD_SLOW[lvl_tc_i]);
      mph_atk_k_o = KW'(MA[mph_tc_i]);
      mph_dec_k_o = KW'(MD[mph_tc_i]);
    end
  end
endmodule

// File: rtl/qd_sens_lim.sv
module qd_sens_lim #(
  parameter int W = 8
) (
  input  logic [W-1:0] lvl_i,
  input  logic [1:0]   prog_i,
  output logic [1:0]   eff_o
);
  import qd_smooth_pkg::*;

  logic [1:0] auto_lim;

  always_comb begin
    if      (int'(lvl_i) >= LVL_THR3) auto_lim = 2'd3;
    else if (int'(lvl_i) >= LVL_THR2) auto_lim = 2'd2;
    else if (int'(lvl_i) >= LVL_THR1) auto_lim = 2'd1;
    else                              auto_lim = 2'd0;
    eff_o = (prog_i < auto_lim) ? prog_i : auto_lim;
  end
endmodule

// File: rtl/qd_smoother.sv
module qd_smoother #(
  parameter int W       = 8,
  parameter int FRAC    = 16,
  parameter int TICK_US = 1000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         hold_i,
  input  logic         search_i,
  input  logic         lvl_fast_i,
  input  logic [1:0]   lvl_tc_i,
  input  logic [1:0]   mph_tc_i,
  input  logic [1:0]   usn_sens_i,
  input  logic [W-1:0] lvl_raw_i,
  input  logic [W-1:0] mph_raw_i,
  input  logic [W-1:0] usn_raw_i,
  input  logic [W-1:0] wam_raw_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] mph_o,
  output logic [W-1:0] usn_o,
  output logic [W-1:0] wam_o,
  output logic [W-1:0] usn_pk_o,
  output logic [W-1:0] wam_pk_o,
  output logic [1:0]   usn_sens_o
);
  import qd_smooth_pkg::*;

  localparam int SW    = W + FRAC;
  localparam int KW    = $clog2(SW + 1);
  localparam int MAX_K = SW;
  localparam int NN    = 2;

  localparam logic [KW-1:0] K_CTRL   = KW'(tc_shift(CTRL_US, TICK_US, MAX_K));
  localparam logic [KW-1:0] K_PK_ATK = KW'(tc_shift(PK_ATK_US, TICK_US, MAX_K));
  localparam logic [KW-1:0] K_PK_DEC = KW'(tc_shift(PK_DEC_US, TICK_US, MAX_K));

  logic          ctrl_step;
  logic [KW-1:0] lvl_atk_k, lvl_dec_k, mph_atk_k, mph_dec_k;

  assign ctrl_step = tick_i & ~hold_i;

  qd_tc_sel #(.TICK_US(TICK_US), .KW(KW), .MAX_K(MAX_K)) u_tc_sel (
    .search_i   (search_i),
    .lvl_fast_i (lvl_fast_i),
    .lvl_tc_i   (lvl_tc_i),
    .mph_tc_i   (mph_tc_i),
    .lvl_atk_k_o(lvl_atk_k),
    .lvl_dec_k_o(lvl_dec_k),
    .mph_atk_k_o(mph_atk_k),
    .mph_dec_k_o(mph_dec_k)
  );

  qd_track #(.W(W), .FRAC(FRAC), .KW(KW)) u_lvl (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(ctrl_step), .x_i(lvl_raw_i),
    .k_atk_i(lvl_atk_k), .k_dec_i(lvl_dec_k), .y_o(lvl_o)
  );

  qd_track #(.W(W), .FRAC(FRAC), .KW(KW)) u_mph (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(ctrl_step), .x_i(mph_raw_i),
    .k_atk_i(mph_atk_k), .k_dec_i(mph_dec_k), .y_o(mph_o)
  );

  // noise paths: [0] ultrasonic noise, [1] wideband AM
  logic [W-1:0] nz_raw  [NN];
  logic [W-1:0] nz_ctrl [NN];
  logic [W-1:0] nz_pk   [NN];

  assign nz_raw[0] = usn_raw_i;
  assign nz_raw[1] = wam_raw_i;

  for (genvar g = 0; g < NN; g++) begin : g_noise
    qd_track #(.W(W), .FRAC(FRAC), .KW(KW)) u_ctrl (
      .clk_i(clk_i), .rst_ni(rst_ni), .step_i(ctrl_step), .x_i(nz_raw[g]),
      .k_atk_i(K_CTRL), .k_dec_i(K_CTRL), .y_o(nz_ctrl[g])
    );
    qd_track #(.W(W), .FRAC(FRAC), .KW(KW)) u_peak (
      .clk_i(clk_i), .rst_ni(rst_ni), .step_i(tick_i), .x_i(nz_raw[g]),
      .k_atk_i(K_PK_ATK), .k_dec_i(K_PK_DEC), .y_o(nz_pk[g])
    );
  end

  assign usn_o    = nz_ctrl[0];
  assign wam_o    = nz_ctrl[1];
  assign usn_pk_o = nz_pk[0];
  assign wam_pk_o = nz_pk[1];

  qd_sens_lim #(.W(W)) u_sens (
    .lvl_i (lvl_o),
    .prog_i(usn_sens_i),
    .eff_o (usn_sens_o)
  );
endmodule

// File: rtl/qd_smoother_chk.sv
module qd_smoother_chk #(
  parameter int W       = 8,
  parameter int TICK_US = 1000
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         hold_i,
  input logic [1:0]   usn_sens_i,
  input logic [W-1:0] lvl_raw_i,
  input logic [W-1:0] usn_raw_i,
  input logic [W-1:0] lvl_o,
  input logic [W-1:0] mph_o,
  input logic [W-1:0] usn_o,
  input logic [W-1:0] wam_o,
  input logic [W-1:0] usn_pk_o,
  input logic [W-1:0] wam_pk_o,
  input logic [1:0]   usn_sens_o
);
  import qd_smooth_pkg::*;

  p_no_tick_still_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(lvl_o) && $stable(mph_o) && $stable(usn_pk_o) && $stable(wam_pk_o)));

  p_rise_bounded_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !hold_i && lvl_raw_i > lvl_o) |=>
      (lvl_o >= $past(lvl_o) && lvl_o <= $past(lvl_raw_i)));

  p_fall_bounded_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !hold_i && lvl_raw_i < lvl_o) |=>
      (lvl_o <= $past(lvl_o) && lvl_o >= $past(lvl_raw_i)));

  p_hold_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> ($stable(lvl_o) && $stable(mph_o) && $stable(usn_o) && $stable(wam_o)));

  p_sens_min_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    usn_sens_o <= usn_sens_i);

  p_sens_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(lvl_o) < LVL_THR1) |-> (usn_sens_o == 2'd0));

  if (TICK_US >= 1000) begin : g_inst
    p_peak_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && usn_raw_i > usn_pk_o) |=> (usn_pk_o == $past(usn_raw_i)));
  end
endmodule

bind qd_smoother qd_smoother_chk #(.W(W), .TICK_US(TICK_US)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .hold_i(hold_i),
  .usn_sens_i(usn_sens_i), .lvl_raw_i(lvl_raw_i), .usn_raw_i(usn_raw_i),
  .lvl_o(lvl_o), .mph_o(mph_o), .usn_o(usn_o), .wam_o(wam_o),
  .usn_pk_o(usn_pk_o), .wam_pk_o(wam_pk_o), .usn_sens_o(usn_sens_o)
);

// File: tb/qd_smoother_tb.sv
`timescale 1ns/1ps
module qd_smoother_tb;
  localparam int W    = 8;
  localparam int FRAC = 16;
  localparam int TICK = 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, hold = 0, search = 0, fast = 0;
  logic [1:0] lsel = 0, msel = 0, sens = 0;
  logic [W-1:0] lraw = 0, mraw = 0, uraw = 0, wraw = 0;
  logic [W-1:0] lvl, mph, usn, wam, upk, wpk;
  logic [1:0] sens_eff;

  int checks = 0, errors = 0;
  longint y [6];

  always #2.5 clk = ~clk;

  qd_smoother #(.W(W), .FRAC(FRAC), .TICK_US(TICK)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .hold_i(hold), .search_i(search),
    .lvl_fast_i(fast), .lvl_tc_i(lsel), .mph_tc_i(msel), .usn_sens_i(sens),
    .lvl_raw_i(lraw), .mph_raw_i(mraw), .usn_raw_i(uraw), .wam_raw_i(wraw),
    .lvl_o(lvl), .mph_o(mph), .usn_o(usn), .wam_o(wam),
    .usn_pk_o(upk), .wam_pk_o(wpk), .usn_sens_o(sens_eff)
  );

  // R2 mapping
  function automatic int kt(longint t_us);
    return $clog2((t_us + TICK - 1) / TICK);
  endfunction

  function automatic longint t_lvl(bit dec, bit f, int s);
    longint a_s[4] = '{3000000, 3000000, 1500000, 500000};
    longint a_f[4] = '{500000, 170000, 60000, 60000};
    longint d_s[4] = '{3000000, 6000000, 1500000, 1500000};
    longint d_f[4] = '{500000, 500000, 170000, 60000};
    if (dec) return f ? d_f[s] : d_s[s];
    return f ? a_f[s] : a_s[s];
  endfunction

  function automatic longint t_mph(bit dec, int s);
    longint a[4] = '{500000, 500000, 500000, 250000};
    longint d[4] = '{12000000, 24000000, 6000000, 6000000};
    return dec ? d[s] : a[s];
  endfunction

  task automatic upd(int i, int x, int ka, int kd);
    longint diff;
    diff = (longint'(x) << FRAC) - y[i];
    y[i] = y[i] + (diff >>> ((diff > 0) ? ka : kd));
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sens_exp(int l, int p);
    int a;
    a = (l >= 64) ? 3 : (l >= 56) ? 2 : (l >= 48) ? 1 : 0;
    return (p < a) ? p : a;
  endfunction

  task automatic compare_all();
    chk("R3 R5 level", int'(lvl), int'(y[0] >>> FRAC));
    chk("R4 R5 multipath", int'(mph), int'(y[1] >>> FRAC));
    chk("R6 noise ctrl", int'(usn), int'(y[2] >>> FRAC));
    chk("R6 wam ctrl", int'(wam), int'(y[3] >>> FRAC));
    chk("R7 noise peak", int'(upk), int'(y[4] >>> FRAC));
    chk("R7 wam peak", int'(wpk), int'(y[5] >>> FRAC));
    chk("R9 sensitivity", int'(sens_eff), sens_exp(int'(y[0] >>> FRAC), int'(sens)));
  endtask

  // one tick: drive at negedge, model after posedge, compare at next negedge
  task automatic do_tick(int l, int m, int u, int w, bit t);
    int la, ld, ma, md;
    @(negedge clk);
    lraw = W'(l); mraw = W'(m); uraw = W'(u); wraw = W'(w); tick = t;
    @(posedge clk);
    la = search ? kt(60000) : kt(t_lvl(0, fast, int'(lsel)));
    ld = search ? kt(60000) : kt(t_lvl(1, fast, int'(lsel)));
    ma = search ? kt(60000) : kt(t_mph(0, int'(msel)));
    md = search ? kt(60000) : kt(t_mph(1, int'(msel)));
    if (t) begin
      if (!hold) begin
        upd(0, l, la, ld);
        upd(1, m, ma, md);
        upd(2, u, kt(1000), kt(1000));
        upd(3, w, kt(1000), kt(1000));
      end
      upd(4, u, kt(1000), kt(10000));
      upd(5, w, kt(1000), kt(10000));
    end
    @(negedge clk);
    tick = 0;
    compare_all();
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) y[i] = 0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 level", int'(lvl), 0);
    chk("R10 peak", int'(upk), 0);
    chk("R10 sens", int'(sens_eff), 0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R1 R2 R3 R4 R5 R6 R7 R9 sweep over all modes
    for (int s = 0; s < 2; s++)
      for (int f = 0; f < 2; f++)
        for (int sel = 0; sel < 4; sel++) begin
          search = s[0]; fast = f[0]; lsel = sel[1:0]; msel = 2'(3 - sel); sens = sel[1:0];
          for (int n = 0; n < 60; n++)
            do_tick(200, 180 - n, (n * 37 + sel * 11) & 255, (n * 53 + 7) & 255, 1'b1);
          sens = 2'(3 - sel);
          for (int n = 0; n < 60; n++)
            do_tick(10, 5, (n * 29) & 255, 255 - ((n * 13) & 255), 1'b1);
        end

    // R8 hold: controls frozen, peaks keep tracking
    search = 1; sens = 3;
    for (int n = 0; n < 40; n++) do_tick(150, 120, 90, 60, 1'b1);
    hold = 1;
    for (int n = 0; n < 20; n++) do_tick(0, 255, (n * 71) & 255, 255 - n, 1'b1);
    @(negedge clk); hold = 0;
    for (int n = 0; n < 10; n++) do_tick(0, 255, 0, 0, 1'b1);

    // R1 no tick: inputs change, nothing moves
    for (int n = 0; n < 10; n++) do_tick(255, 0, 255, 255, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule